// File: doc/BRIEF.md
# Asynchronous External Memory Controller

This block runs single read and write cycles on an external asynchronous 16-bit memory. An internal client presents an address, a direction flag and write data on a request/acknowledge port. The controller then drives the memory pins through three timed phases: setup, strobe and hold. It returns read data with a one-cycle acknowledge. Phase lengths, the gap between accesses and the extended-wait limit are static configuration inputs, all counted in cycles of the controller clock.

The top address bits select one of several chip-enable outputs. In normal mode the selected enable stays low from the first setup cycle to the last hold cycle. In select-strobe mode the enable is low only while the output enable or write enable is low. When extended wait is enabled, a wait input from the memory passes through a two-flop synchroniser and can freeze the strobe countdown while four strobe cycles remain. A programmable limit stops a stuck wait. Reaching that limit sets a sticky timeout flag.

Top module: `xmem_async_ctrl`

## Requirements
- R1: A read drives output enable low for exactly strobe+1 cycles. Chip enable is low for setup+1 cycles before that and hold+1 cycles after it. Each field covers its full range (setup 0–15, strobe 0–63, hold 0–7), and write enable stays high.
- R2: A write drives write enable low for exactly strobe+1 cycles, using the write setup, strobe and hold fields. The data bus carries the request's write data in every setup, strobe and hold cycle, and output enable stays high throughout.
- R3: Address bit ADDR_W-1 selects the chip enable: 0 drives bit 0 of the enable bus low and 1 drives bit 1 low. At most one enable is low at a time, and the memory address carries the remaining low address bits.
- R4: With select-strobe set, the selected chip enable is low exactly in the strobe cycles and high in setup and hold. The access still lasts setup+strobe+hold+3 cycles from acceptance to acknowledge.
- R5: When a new request is already waiting at the acknowledge, all chip enables stay high for exactly turnaround+1 cycles (1–4) before the next setup begins.
- R6: The acknowledge is high for exactly one cycle, the last hold cycle. For a read, the read data at that moment equals the bus value sampled in the last strobe cycle.
- R7: With extended wait enabled, a synchronised wait level seen in the strobe cycle that has 4 strobe cycles left holds the countdown there for as long as the wait stays high. A wait level that is first seen later is ignored, and with extended wait disabled the wait input has no effect.
- R8: After (limit+1)*16 held strobe cycles, the strobe ends even if the wait is still high. The hold phase then runs its normal length and the timeout flag goes high. Normal waits that release in time leave the flag low.
- R9: The timeout flag stays high through later accesses until the clear input is pulsed; a new timeout in the same cycle wins over the clear.
- R10: After reset, all chip enables, output enable and write enable are high, acknowledge is low and the timeout flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all timing counts are in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address; MSBs select the chip enable |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with acknowledge |
| cfg_rd_setup | input | 4 | Read setup cycles minus one |
| cfg_rd_strobe | input | 6 | Read strobe cycles minus one |
| cfg_rd_hold | input | 3 | Read hold cycles minus one |
| cfg_wr_setup | input | 4 | Write setup cycles minus one |
| cfg_wr_strobe | input | 6 | Write strobe cycles minus one |
| cfg_wr_hold | input | 3 | Write hold cycles minus one |
| cfg_turn | input | 2 | Turnaround cycles minus one |
| cfg_sel_strobe | input | 1 | Chip enable follows the strobe only |
| cfg_wait_en | input | 1 | Enables strobe extension by the wait input |
| cfg_wait_max | input | 8 | Wait limit: (value+1)*16 cycles |
| timeout_clr | input | 1 | Clears the timeout flag |
| timeout_flag | output | 1 | Sticky wait-timeout indication |
| mem_ce_n | output | NCS | Active-low chip enables |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | ADDR_W-CSW | Memory address |
| mem_dq | inout | 16 | Bidirectional data bus |
| mem_wait | input | 1 | Asynchronous wait from memory, high = stretch |

## Verification
A corrupt phase counter shows up in the next access as a wrong number of low cycles on a chip enable, output enable or write enable. It also moves the acknowledge away from the last chip-enable cycle. A wrong synchroniser or freeze condition changes the strobe length in the same access. This shows most clearly at the boundary between the wait level that counts and the one that is too late, since those differ by a single cycle. A lost or spurious timeout state is visible on the flag in the hold phase of that access, or one access later because the flag is sticky.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
    localparam int DATA_W    = 16;
    localparam int SETUP_W   = 4;
    localparam int STROBE_W  = 6;
    localparam int HOLD_W    = 3;
    localparam int TURN_W    = 2;
    localparam int WMAX_W    = 8;
    localparam int WAIT_ULOG = 4;   // wait limit unit = 2**WAIT_ULOG cycles
    localparam int WAIT_LEAD = 4;   // strobe cycles left when wait is examined
    localparam int CNT_W     = STROBE_W;
    localparam int WCNT_W    = WMAX_W + WAIT_ULOG;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_TURN
    } phase_e;

    typedef struct packed {
        logic [SETUP_W-1:0]  setup;
        logic [STROBE_W-1:0] strobe;
        logic [HOLD_W-1:0]   hold;
    } phase_len_t;

    function automatic phase_len_t pick_len(input logic wr,
                                            input phase_len_t rd_len,
                                            input phase_len_t wr_len);
        return wr ? wr_len : rd_len;
    endfunction

    // last held-strobe count before timeout: (m+1)*16 - 1
    function automatic logic [WCNT_W-1:0] wait_last(input logic [WMAX_W-1:0] m);
        return {m, {WAIT_ULOG{1'b1}}};
    endfunction
endpackage

// File: rtl/xmem_wait_sync.sv
module xmem_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[STAGES-2:0], din};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/xmem_phase_fsm.sv
module xmem_phase_fsm
    import xmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  phase_len_t        len,
    input  logic [TURN_W-1:0] turn,
    input  logic              wait_en,
    input  logic [WMAX_W-1:0] wait_max,
    input  logic              wait_s,
    output phase_e            phase,
    output logic              accept,
    output logic              strobe_end,
    output logic              timeout_hit,
    output logic              ack
);
    logic [CNT_W-1:0]  cnt;
    logic [WCNT_W-1:0] wcnt;
    logic              freeze;
    logic              wait_done;

    assign accept    = req_valid &&
                       (phase == PH_IDLE || (phase == PH_TURN && cnt == '0));
    assign freeze    = wait_en && wait_s && (cnt == CNT_W'(WAIT_LEAD - 1));
    assign wait_done = (wcnt == wait_last(wait_max));

    assign strobe_end  = (phase == PH_STROBE) &&
                         (freeze ? wait_done : (cnt == '0));
    assign timeout_hit = (phase == PH_STROBE) && freeze && wait_done;
    assign ack         = (phase == PH_HOLD) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            wcnt  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase <= PH_SETUP;
                        cnt   <= CNT_W'(len.setup);
                    end
                end
                PH_TURN: begin
                    if (accept) begin
                        phase <= PH_SETUP;
                        cnt   <= CNT_W'(len.setup);
                    end else if (cnt == '0) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_STROBE;
                        cnt   <= CNT_W'(len.strobe);
                        wcnt  <= '0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (freeze) begin
                        if (wait_done) begin
                            phase <= PH_HOLD;
                            cnt   <= CNT_W'(len.hold);
                        end else begin
                            wcnt <= wcnt + 1'b1;
                        end
                    end else if (cnt == '0) begin
                        phase <= PH_HOLD;
                        cnt   <= CNT_W'(len.hold);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) begin
                        phase <= PH_TURN;
                        cnt   <= CNT_W'(turn);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);                                                   // R6
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STROBE) |-> (wcnt <= wait_last(wait_max)));         // R8
    AST_ACK_TO_TURN: assert property (@(posedge clk) disable iff (rst)
        ack |=> (phase == PH_TURN));                                     // R5
endmodule

// File: rtl/xmem_async_ctrl.sv
module xmem_async_ctrl
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NCS    = 2,
    localparam int CSW   = (NCS > 1) ? $clog2(NCS) : 1,
    localparam int MA_W  = ADDR_W - CSW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                req_ack,
    output logic [DATA_W-1:0]   rsp_rdata,
    input  logic [SETUP_W-1:0]  cfg_rd_setup,
    input  logic [STROBE_W-1:0] cfg_rd_strobe,
    input  logic [HOLD_W-1:0]   cfg_rd_hold,
    input  logic [SETUP_W-1:0]  cfg_wr_setup,
    input  logic [STROBE_W-1:0] cfg_wr_strobe,
    input  logic [HOLD_W-1:0]   cfg_wr_hold,
    input  logic [TURN_W-1:0]   cfg_turn,
    input  logic                cfg_sel_strobe,
    input  logic                cfg_wait_en,
    input  logic [WMAX_W-1:0]   cfg_wait_max,
    input  logic                timeout_clr,
    output logic                timeout_flag,
    output logic [NCS-1:0]      mem_ce_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic [MA_W-1:0]     mem_addr,
    inout  wire  [DATA_W-1:0]   mem_dq,
    input  logic                mem_wait
);
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              wait_s;
    phase_e            phase;
    logic              accept, strobe_end, timeout_hit, ack;
    logic              cur_wr;
    phase_len_t        len;
    logic              in_access, in_strobe, ce_act, dq_drive;
    logic [CSW-1:0]    bank;

    assign cur_wr = accept ? req_write : wr_q;
    assign len    = pick_len(cur_wr,
                             '{setup: cfg_rd_setup, strobe: cfg_rd_strobe, hold: cfg_rd_hold},
                             '{setup: cfg_wr_setup, strobe: cfg_wr_strobe, hold: cfg_wr_hold});

    xmem_wait_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (mem_wait),
        .q   (wait_s)
    );

    xmem_phase_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .len         (len),
        .turn        (cfg_turn),
        .wait_en     (cfg_wait_en),
        .wait_max    (cfg_wait_max),
        .wait_s      (wait_s),
        .phase       (phase),
        .accept      (accept),
        .strobe_end  (strobe_end),
        .timeout_hit (timeout_hit),
        .ack         (ack)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                      rdata_q <= '0;
        else if (strobe_end && !wr_q) rdata_q <= mem_dq;
    end

    always_ff @(posedge clk) begin
        if (rst)              timeout_flag <= 1'b0;
        else if (timeout_hit) timeout_flag <= 1'b1;
        else if (timeout_clr) timeout_flag <= 1'b0;
    end

    assign in_strobe = (phase == PH_STROBE);
    assign in_access = (phase == PH_SETUP) || in_strobe || (phase == PH_HOLD);
    assign ce_act    = cfg_sel_strobe ? in_strobe : in_access;
    assign dq_drive  = wr_q && in_access;
    assign bank      = (NCS > 1) ? addr_q[ADDR_W-1 -: CSW] : '0;

    generate
        for (genvar b = 0; b < NCS; b++) begin : g_ce
            assign mem_ce_n[b] = !(ce_act && (bank == CSW'(b)));
        end
    endgenerate

    assign mem_oe_n  = !(in_strobe && !wr_q);
    assign mem_we_n  = !(in_strobe && wr_q);
    assign mem_addr  = addr_q[MA_W-1:0];
    assign mem_dq    = dq_drive ? wdata_q : {DATA_W{1'bz}};
    assign req_ack   = ack;
    assign rsp_rdata = rdata_q;

    AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_ce_n));                                            // R3
    AST_NO_CONTEND: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !dq_drive);                                        // R2
    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (rst)
        (timeout_flag && !timeout_clr) |=> timeout_flag);                // R9
    AST_SEL_CE: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel_strobe && mem_oe_n && mem_we_n) |-> (&mem_ce_n));       // R4
endmodule

// File: tb/sim_xmem_async_ctrl.sv
module sim_xmem_async_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ack;
    logic [15:0] rsp_rdata;
    logic [3:0]  cfg_rd_setup = '0, cfg_wr_setup = '0;
    logic [5:0]  cfg_rd_strobe = '0, cfg_wr_strobe = '0;
    logic [2:0]  cfg_rd_hold = '0, cfg_wr_hold = '0;
    logic [1:0]  cfg_turn = '0;
    logic        cfg_sel_strobe = 1'b0, cfg_wait_en = 1'b0;
    logic [7:0]  cfg_wait_max = '0;
    logic        timeout_clr = 1'b0;
    logic        timeout_flag;
    logic [1:0]  mem_ce_n;
    logic        mem_oe_n, mem_we_n;
    logic [10:0] mem_addr;
    wire  [15:0] mem_dq;
    logic        mem_wait = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    function automatic logic [15:0] pattern(input logic [10:0] a);
        return {5'b10110, a} ^ 16'h0F0F;
    endfunction

    assign mem_dq = !mem_oe_n ? pattern(mem_addr) : 16'hzzzz;

    xmem_async_ctrl u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ack(req_ack), .rsp_rdata(rsp_rdata),
        .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
        .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
        .cfg_turn(cfg_turn), .cfg_sel_strobe(cfg_sel_strobe), .cfg_wait_en(cfg_wait_en),
        .cfg_wait_max(cfg_wait_max), .timeout_clr(timeout_clr), .timeout_flag(timeout_flag),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_wait(mem_wait)
    );

    task automatic chk(input string what, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    task automatic chk_eq(input string what, input int act, input int exp);
        chk(what, act == exp, act, exp);
    endtask

    // Runs one access; w_at = strobe-cycle index where wait rises (-1 none)
    task automatic do_access(input bit wr, input logic [11:0] addr, input logic [15:0] wd,
                             input int w_at, input int w_len,
                             output int s_c, output int st_c, output int h_c, output int tot,
                             output int bad_ce, output int bad_dq, output int bad_oe,
                             output logic [15:0] rd_ack);
        logic [1:0] exp_ce;
        bit seen, done, stb;
        int wl;
        exp_ce = addr[11] ? 2'b01 : 2'b10;
        s_c = 0; st_c = 0; h_c = 0; tot = 0; bad_ce = 0; bad_dq = 0; bad_oe = 0;
        rd_ack = '0; seen = 0; done = 0; wl = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        while (!done) begin
            @(negedge clk);
            tot++;
            stb = !mem_oe_n || !mem_we_n;
            if (wl > 0) begin
                wl--;
                if (wl == 0) mem_wait = 1'b0;
            end
            if (stb) begin
                if (st_c == w_at && w_len > 0) begin
                    mem_wait = 1'b1;
                    wl = w_len;
                end
                st_c++;
                seen = 1;
                if (mem_ce_n !== exp_ce) bad_ce++;
                if (wr && mem_dq !== wd) bad_dq++;
                if (wr && !mem_oe_n) bad_oe++;
                if (!wr && !mem_we_n) bad_oe++;
            end else if (mem_ce_n != 2'b11) begin
                if (mem_ce_n !== exp_ce) bad_ce++;
                if (wr && mem_dq !== wd) bad_dq++;
                if (seen) h_c++; else s_c++;
            end
            if (req_ack) begin
                rd_ack = rsp_rdata;
                req_valid = 1'b0;
                done = 1;
            end
            if (tot > 20000) done = 1;
        end
        mem_wait = 1'b0;
    endtask

    task automatic chk_after(input string tag);
        @(negedge clk);
        chk_eq({tag, " ce high after ack"}, int'(mem_ce_n), 3);
        chk_eq({tag, " ack single cycle R6"}, int'(req_ack), 0);
    endtask

    task automatic t_reset();
        chk_eq("R10 ce_n reset", int'(mem_ce_n), 3);
        chk_eq("R10 oe_n reset", int'(mem_oe_n), 1);
        chk_eq("R10 we_n reset", int'(mem_we_n), 1);
        chk_eq("R10 ack reset", int'(req_ack), 0);
        chk_eq("R10 timeout reset", int'(timeout_flag), 0);
    endtask

    task automatic t_read();
        int s, st, h, tot, bce, bdq, boe; logic [15:0] rd;
        cfg_rd_setup = 4'd2; cfg_rd_strobe = 6'd4; cfg_rd_hold = 3'd1;
        do_access(0, 12'h123, '0, -1, 0, s, st, h, tot, bce, bdq, boe, rd);
        chk_eq("R1 read setup", s, 3);
        chk_eq("R1 read strobe", st, 5);
        chk_eq("R1 read hold (ack on last hold R6)", h, 2);
        chk_eq("R1 we stays high on read", boe, 0);
        chk_eq("R6 read data", int'(rd), int'(pattern(11'h123)));
        chk_eq("R3 bank0 enable", bce, 0);
        chk_after("R6 read");
    endtask

    task automatic t_write();
        int s, st, h, tot, bce, bdq, boe; logic [15:0] rd;
        cfg_wr_setup = 4'd0; cfg_wr_strobe = 6'd2; cfg_wr_hold = 3'd3;
        do_access(1, 12'h8A5, 16'hBEEF, -1, 0, s, st, h, tot, bce, bdq, boe, rd);
        chk_eq("R2 write setup", s, 1);
        chk_eq("R2 write strobe", st, 3);
        chk_eq("R2 write hold", h, 4);
        chk_eq("R2 write data driven", bdq, 0);
        chk_eq("R2 oe high on write", boe, 0);
        chk_eq("R3 bank1 enable", bce, 0);
        chk_after("R2 write");
    endtask

    task automatic t_bounds();
        int s, st, h, tot, bce, bdq, boe; logic [15:0] rd;
        cfg_rd_setup = 4'd15; cfg_rd_strobe = 6'd63; cfg_rd_hold = 3'd7;
        do_access(0, 12'h7FF, '0, -1, 0, s, st, h, tot, bce, bdq, boe, rd);
        chk_eq("R1 max setup", s, 16);
        chk_eq("R1 max strobe", st, 64);
        chk_eq("R1 max hold", h, 8);
        chk_eq("R6 read data max", int'(rd), int'(pattern(11'h7FF)));
        cfg_rd_setup = 4'd0; cfg_rd_strobe = 6'd0; cfg_rd_hold = 3'd0;
        do_access(0, 12'h001, '0, -1, 0, s, st, h, tot, bce, bdq, boe, rd);
        chk_eq("R1 min setup", s, 1);
        chk_eq("R1 min strobe", st, 1);
        chk_eq("R1 min hold", h, 1);
        chk_eq("R6 read data min", int'(rd), int'(pattern(11'h001)));
    endtask

    task automatic t_sel();
        int s, st, h, tot, bce, bdq, boe; logic [15:0] rd;
        cfg_sel_strobe = 1'b1;
        cfg_rd_setup = 4'd2; cfg_rd_strobe = 6'd4; cfg_rd_hold = 3'd1;
        do_access(0, 12'h955, '0, -1, 0, s, st, h, tot, bce, bdq, boe, rd);
        chk_eq("R4 sel strobe len", st, 5);
        chk_eq("R4 ce high outside strobe", s + h, 0);
        chk_eq("R4 ce matches strobe", bce, 0);
        chk_eq("R4 total cycles", tot, 10);
        cfg_sel_strobe = 1'b0;
    endtask

    task automatic t_turn(input logic [1:0] tf);
        int gap;
        cfg_turn = tf;
        cfg_rd_setup = 4'd0; cfg_rd_strobe = 6'd1; cfg_rd_hold = 3'd0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h010;
        do @(negedge clk); while (!req_ack);
        req_addr = 12'h020;           // next request already waiting
        gap = 0;
        @(negedge clk);
        while (mem_ce_n == 2'b11 && gap < 50) begin
            gap++;
            @(negedge clk);
        end
        chk_eq("R5 turnaround gap", gap, int'(tf) + 1);
        do @(negedge clk); while (!req_ack);
        req_valid = 1'b0;
        chk_after("R5");
    endtask

    task automatic t_wait(input bit en, input int at, input int len, input int exp_st, input string tag);
        int s, st, h, tot, bce, bdq, boe; logic [15:0] rd;
        cfg_wait_en = en;
        cfg_rd_setup = 4'd0; cfg_rd_strobe = 6'd9; cfg_rd_hold = 3'd0;
        do_access(0, 12'h0AA, '0, at, len, s, st, h, tot, bce, bdq, boe, rd);
        chk_eq({"R7 ", tag}, st, exp_st);
        chk_eq("R6 read data after wait", int'(rd), int'(pattern(11'h0AA)));
        chk_eq("R8 no timeout on normal wait", int'(timeout_flag), 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_timeout();
        int s, st, h, tot, bce, bdq, boe; logic [15:0] rd;
        cfg_wait_en = 1'b1; cfg_wait_max = 8'd0;
        cfg_rd_setup = 4'd0; cfg_rd_strobe = 6'd9; cfg_rd_hold = 3'd1;
        do_access(0, 12'h0BB, '0, 0, 300, s, st, h, tot, bce, bdq, boe, rd);
        chk_eq("R8 timeout strobe limit 16", st, 22);
        chk_eq("R8 hold after timeout", h, 2);
        chk_eq("R8 flag set", int'(timeout_flag), 1);
        repeat (4) @(negedge clk);
        do_access(0, 12'h0BC, '0, -1, 0, s, st, h, tot, bce, bdq, boe, rd);
        chk_eq("R9 flag sticky", int'(timeout_flag), 1);
        timeout_clr = 1'b1;
        @(negedge clk);
        timeout_clr = 1'b0;
        chk_eq("R9 flag cleared", int'(timeout_flag), 0);
        cfg_wait_max = 8'd1;
        repeat (4) @(negedge clk);
        do_access(0, 12'h0BD, '0, 0, 300, s, st, h, tot, bce, bdq, boe, rd);
        chk_eq("R8 timeout strobe limit 32", st, 38);
        chk_eq("R8 flag set again", int'(timeout_flag), 1);
        cfg_wait_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read();
        t_write();
        t_bounds();
        t_sel();
        t_turn(2'd2);
        t_turn(2'd0);
        t_turn(2'd3);
        t_wait(1, 0, 8, 14, "early wait stretches");
        t_wait(1, 4, 3, 13, "wait at 4-left boundary");
        t_wait(1, 5, 3, 10, "late wait ignored");
        t_wait(0, 0, 8, 10, "wait disabled ignored");
        t_timeout();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog run incomplete act=running exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule